// File: doc/BRIEF.md
# DMA Controller Interrupt Aggregator

This block is the controller-wide register block of a multi-channel DMA engine. Each channel presents a set of interrupt control bits, a matching set of interrupt status bits, a two-bit priority level and an idle flag. A channel is asking for service when the two bit sets share at least one set bit.

The block keeps four pending words and four enable words, one pair per priority level. When a channel asks for service and the enable bit for that channel at its own level is set, the channel's bit in that level's pending word is set. Software clears pending bits by writing ones. A pending bit is never lost when a new channel event lands in the same cycle as that clear. Each level drives its own registered interrupt line. Level 0 alone is enough when all channels keep the default priority.

The block also decodes the register address space. The low 256-byte window holds the controller-wide words. Window n+1 selects channel n through a one-hot strobe and a byte offset, so that the channel logic can answer the access.

Top module: `dmairq_hub`

## Requirements
- R1: After reset, all pending words and enable words are zero, every `irq_o` line is low and `bus_rvalid` is low.
- R2: Channel n asks for service when its `ch_int_ctl` slice ANDed with its `ch_int_stat` slice is nonzero. If enable word `ch_prio[n]` has bit n set, bit n of pending word `ch_prio[n]` is set at the next clock edge. A channel whose control and status bits do not overlap sets nothing.
- R3: A channel asking for service while its enable bit at its level is clear leaves every pending word unchanged.
- R4: A write to pending word L (byte offset 4*L, L = 0..3) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: When a set and a write-1 clear hit the same pending bit in the same cycle, the bit ends up set. Other bits cleared by the same write still clear.
- R6: `irq_o[L]` is a register that takes the OR of (pending word L AND enable word L). It follows a pending change one cycle later. Clearing the enable bit drops the line one cycle after the enable write and leaves the pending bit in place.
- R7: Enable word L sits at byte offset 0x10 + 4*L. It is read/write over bits 0..NCH-1 and reads zero above them.
- R8: A read at byte offset 0x2C returns `ch_idle` in bits 0..NCH-1, with 1 meaning idle.
- R9: A read (`bus_en`=1, `bus_we`=0) gives `bus_rvalid`=1 and `bus_rdata` on the cycle after the request, and `bus_rvalid`=0 otherwise. Unmapped controller-wide offsets read zero, and writes to them have no effect. Reads in a channel window return zero from this block.
- R10: While `bus_en` is 1, `chan_sel[n]` is 1 exactly when `bus_addr[ADDR_W-1:8]` equals n+1. `chan_off` always equals `bus_addr[7:0]`. A controller-wide address selects no channel.
- R11: A channel's event sets only the pending word chosen by its `ch_prio` field, and only `irq_o` of that level rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| chan_sel | output | NCH | One-hot channel window strobe |
| chan_off | output | 8 | Byte offset inside the addressed window |
| ch_int_ctl | input | NCH*COND_W | Per-channel interrupt control bits |
| ch_int_stat | input | NCH*COND_W | Per-channel interrupt status bits |
| ch_prio | input | NCH*2 | Per-channel priority level |
| ch_idle | input | NCH | Per-channel idle flag |
| irq_o | output | 4 | Interrupt line per priority level |

## Verification
A channel event setting a pending bit and a software write-1 clear of the same word can land in the same clock edge. The bench provokes this by holding one channel's request active during the clear write of the word it targets. In the same write it also clears a second bit whose channel is quiet. The bench then reads the word back and expects the held bit to stay set and the quiet bit to be gone. Enable writes and interrupt-line updates also collide, and the bench judges that collision by the cycle in which `irq_o` falls.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int NLVL       = 4;   // priority levels
  localparam int LVL_W      = 2;   // width of a priority field
  localparam int WIN_SHIFT  = 8;   // each window spans 256 bytes
  localparam int WORD_W     = 6;   // word index inside a window
  localparam int PEND_WORD0 = 0;   // byte 0x00
  localparam int EN_WORD0   = 4;   // byte 0x10
  localparam int IDLE_WORD  = 11;  // byte 0x2C
endpackage

// File: rtl/dmairq_decode.sv
module dmairq_decode
  import dmairq_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int ADDR_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                glob_hit_o,
  output logic [WORD_W-1:0]   word_o,
  output logic [NCH-1:0]      chan_sel_o,
  output logic [7:0]          chan_off_o
);
  localparam int REG_W = ADDR_W - WIN_SHIFT;

  logic [REG_W-1:0] region;

  assign region     = addr_i[ADDR_W-1:WIN_SHIFT];
  assign glob_hit_o = (region == '0);
  assign word_o     = addr_i[WIN_SHIFT-1:2];
  assign chan_off_o = addr_i[WIN_SHIFT-1:0];

  for (genvar n = 0; n < NCH; n++) begin : g_sel
    assign chan_sel_o[n] = en_i && (region == REG_W'(n + 1));
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({glob_hit_o & en_i, chan_sel_o})); // R10
endmodule

// File: rtl/dmairq_route.sv
module dmairq_route
  import dmairq_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int COND_W = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NCH*COND_W-1:0]         ctl_i,
  input  logic [NCH*COND_W-1:0]         stat_i,
  input  logic [NCH*LVL_W-1:0]          prio_i,
  input  logic [NLVL-1:0][NCH-1:0]      en_i,
  output logic [NLVL-1:0][NCH-1:0]      set_o
);
  logic [NCH-1:0] req;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic [NLVL-1:0] col;
    assign req[n] = |(ctl_i[n*COND_W +: COND_W] & stat_i[n*COND_W +: COND_W]);
    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
      assign set_o[l][n] = req[n] && (prio_i[n*LVL_W +: LVL_W] == LVL_W'(l))
                           && en_i[l][n];
      assign col[l] = set_o[l][n];
    end

    AST_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col)); // R11
  end
endmodule

// File: rtl/dmairq_level.sv
module dmairq_level #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_i,
  input  logic           clr_we_i,
  input  logic           en_we_i,
  input  logic [NCH-1:0] wdata_i,
  output logic [NCH-1:0] pend_o,
  output logic [NCH-1:0] en_o,
  output logic           irq_o
);
  logic [NCH-1:0] pend_q, en_q, clr_mask;
  logic           irq_q;

  assign clr_mask = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr_mask) | set_i;
      if (en_we_i) en_q <= wdata_i;
      irq_q  <= |(pend_q & en_q);
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i))); // R5

  AST_CLR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && |(wdata_i & ~set_i)) |=> ((pend_o & $past(wdata_i & ~set_i)) == '0)); // R4

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(set_i)) == '0)); // R2

  AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(pend_o & en_o)))); // R6
endmodule

// File: rtl/dmairq_hub.sv
module dmairq_hub
  import dmairq_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int COND_W = 5,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_en,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    bus_rvalid,
  output logic [NCH-1:0]          chan_sel,
  output logic [7:0]              chan_off,
  input  logic [NCH*COND_W-1:0]   ch_int_ctl,
  input  logic [NCH*COND_W-1:0]   ch_int_stat,
  input  logic [NCH*LVL_W-1:0]    ch_prio,
  input  logic [NCH-1:0]          ch_idle,
  output logic [NLVL-1:0]         irq_o
);
  logic                     glob_hit;
  logic [WORD_W-1:0]        word;
  logic [NLVL-1:0][NCH-1:0] pend, en, set;
  logic [DATA_W-1:0]        rd_mux, rdata_q;
  logic                     rvalid_q, glob_wr, rd_req;
  logic                     unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NCH];
  assign glob_wr = bus_en && bus_we && glob_hit;
  assign rd_req  = bus_en && !bus_we;

  dmairq_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .en_i(bus_en), .addr_i(bus_addr),
    .glob_hit_o(glob_hit), .word_o(word),
    .chan_sel_o(chan_sel), .chan_off_o(chan_off)
  );

  dmairq_route #(.NCH(NCH), .COND_W(COND_W)) u_route (
    .clk(clk), .rst_n(rst_n), .ctl_i(ch_int_ctl), .stat_i(ch_int_stat),
    .prio_i(ch_prio), .en_i(en), .set_o(set)
  );

  for (genvar l = 0; l < NLVL; l++) begin : g_level
    dmairq_level #(.NCH(NCH)) u_level (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (set[l]),
      .clr_we_i (glob_wr && (word == WORD_W'(PEND_WORD0 + l))),
      .en_we_i  (glob_wr && (word == WORD_W'(EN_WORD0 + l))),
      .wdata_i  (bus_wdata[NCH-1:0]),
      .pend_o   (pend[l]),
      .en_o     (en[l]),
      .irq_o    (irq_o[l])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (glob_hit) begin
      for (int l = 0; l < NLVL; l++) begin
        if (word == WORD_W'(PEND_WORD0 + l)) rd_mux[NCH-1:0] = pend[l];
        if (word == WORD_W'(EN_WORD0 + l))   rd_mux[NCH-1:0] = en[l];
      end
      if (word == WORD_W'(IDLE_WORD)) rd_mux[NCH-1:0] = ch_idle;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_req;
      rdata_q  <= rd_req ? rd_mux : '0;
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = rdata_q;

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid); // R9

  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && glob_hit && word == WORD_W'(IDLE_WORD))
      |=> (bus_rdata[NCH-1:0] == $past(ch_idle))); // R8
endmodule

// File: tb/dmairq_hub_tb_top.sv
module dmairq_hub_tb_top;
  localparam int NCH = 4, COND_W = 3, ADDR_W = 12, DATA_W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid;
  logic [NCH-1:0] chan_sel;
  logic [7:0] chan_off;
  logic [NCH*COND_W-1:0] ch_int_ctl = '0, ch_int_stat = '0;
  logic [NCH*2-1:0] ch_prio = '0;
  logic [NCH-1:0] ch_idle = '0;
  logic [3:0] irq_o;

  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  dmairq_hub #(.NCH(NCH), .COND_W(COND_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .chan_sel(chan_sel), .chan_off(chan_off), .ch_int_ctl(ch_int_ctl),
    .ch_int_stat(ch_int_stat), .ch_prio(ch_prio), .ch_idle(ch_idle), .irq_o(irq_o)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    tick();
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  // overlapping control/status => request; disjoint => no request
  task automatic req(int n, bit on, bit overlap = 1'b1);
    ch_int_ctl[n*COND_W +: COND_W]  = on ? 3'b101 : 3'b000;
    ch_int_stat[n*COND_W +: COND_W] = on ? (overlap ? 3'b100 : 3'b010) : 3'b000;
  endtask

  task automatic clear_all();
    for (int l = 0; l < 4; l++) wr(ADDR_W'(4*l), 32'hF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    tick(); tick();
    chk("R1 rvalid in reset", {31'b0, bus_rvalid}, 0);
    chk("R1 irq in reset", {28'b0, irq_o}, 0);
    rst_n = 1'b1;
    tick();
    for (int l = 0; l < 8; l++) begin
      rd(ADDR_W'(4*l), d);
      chk("R1 word after reset", d, 0);
    end
    tick();
    chk("R9 rvalid idle", {31'b0, bus_rvalid}, 0);

    // R7 enable words read/write
    for (int l = 0; l < 4; l++) begin
      wr(ADDR_W'(16 + 4*l), 32'hA5A5_5A50 ^ l);
      rd(ADDR_W'(16 + 4*l), d);
      chk("R7 enable readback", d, (32'h0 ^ l) & 32'hF);
      chk("R9 rvalid on read", {31'b0, bus_rvalid}, 1);
    end

    // R2/R11/R6 sweep over channel x level
    for (int l = 0; l < 4; l++) wr(ADDR_W'(16 + 4*l), 32'hF);
    for (int n = 0; n < NCH; n++) begin
      for (int l = 0; l < 4; l++) begin
        ch_prio[n*2 +: 2] = 2'(l);
        req(n, 1'b1);
        tick();
        req(n, 1'b0);
        chk("R6 irq one cycle late", {28'b0, irq_o}, 0);
        tick();
        chk("R11 irq level", {28'b0, irq_o}, 32'h1 << l);
        for (int k = 0; k < 4; k++) begin
          rd(ADDR_W'(4*k), d);
          chk("R2 R11 pending word", d, (k == l) ? (32'h1 << n) : 0);
        end
        wr(ADDR_W'(4*l), 32'hF);
        ch_prio[n*2 +: 2] = 2'd0;
      end
    end
    tick();

    // R2 disjoint control/status bits
    req(2, 1'b1, 1'b0);
    tick();
    req(2, 1'b0);
    rd(12'h000, d);
    chk("R2 no overlap no set", d, 0);

    // R3 enable clear
    wr(12'h010, 32'h7);
    req(3, 1'b1);
    tick();
    req(3, 1'b0);
    rd(12'h000, d);
    chk("R3 masked event", d, 0);
    wr(12'h010, 32'hF);

    // R4 partial write-1 clear
    for (int n = 0; n < NCH; n++) req(n, 1'b1);
    tick();
    for (int n = 0; n < NCH; n++) req(n, 1'b0);
    wr(12'h000, 32'h5);
    rd(12'h000, d);
    chk("R4 w1c partial", d, 32'hA);
    wr(12'h000, 32'h0);
    rd(12'h000, d);
    chk("R4 zero write keeps", d, 32'hA);
    clear_all();

    // R5 collision: ch1 event during clear of bits 1,2
    req(1, 1'b1); req(2, 1'b1);
    tick();
    req(2, 1'b0);
    wr(12'h000, 32'h6);
    req(1, 1'b0);
    rd(12'h000, d);
    chk("R5 set wins", d, 32'h2);
    clear_all();
    tick(); tick();

    // R6 enable masking
    req(0, 1'b1);
    tick();
    req(0, 1'b0);
    tick();
    chk("R6 irq up", {28'b0, irq_o}, 1);
    wr(12'h010, 32'h0);
    chk("R6 irq before mask takes effect", {28'b0, irq_o}, 1);
    tick();
    chk("R6 irq masked", {28'b0, irq_o}, 0);
    rd(12'h000, d);
    chk("R6 pending kept", d, 1);
    clear_all();

    // R8 idle sweep
    for (int v = 0; v < 16; v++) begin
      ch_idle = 4'(v);
      rd(12'h02C, d);
      chk("R8 idle word", d, v);
    end

    // R9 unmapped offsets
    wr(12'h020, 32'hF);
    wr(12'h028, 32'hF);
    rd(12'h020, d);
    chk("R9 unmapped read", d, 0);
    for (int l = 0; l < 4; l++) begin
      rd(ADDR_W'(4*l), d);
      chk("R9 unmapped write no effect", d, 0);
    end

    // R10 window decode sweep
    for (int k = 0; k < 7; k++) begin
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = {4'(k), 8'h3C};
      #1;
      chk("R10 chan_sel", {28'b0, chan_sel}, (k >= 1 && k <= NCH) ? (32'h1 << (k - 1)) : 0);
      chk("R10 chan_off", {24'b0, chan_off}, 32'h3C);
      tick();
      bus_en = 1'b0;
      chk("R9 window read zero", bus_rdata, 0);
    end
    bus_addr = 12'h010;
    #1;
    chk("R10 no strobe when idle", {28'b0, chan_sel}, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule